// File: doc/BRIEF.md
# Multiplexed Parallel Register Interface

This block is a byte-wide slave for an asynchronous microcontroller bus. The host talks to it through four active-low control pins (select, read strobe, write strobe and a snapshot-request pin) and an 8-bit data bus. For on-chip pad wiring the bus is split into an input byte, an output byte and an output enable. Every transfer has two phases. A write strobe first sets the register pointer. A read strobe then returns the addressed byte, or a second write strobe stores a byte at that address.

A position snapshot can be requested in two ways: by writing the sample command to the command register, or by pulling the snapshot-request pin low. Each request clears the data-valid flag, advances an 8-bit life counter and, two clock cycles later, loads the snapshot registers from the position source and sets the valid flag again. The position source is modelled here as a counter that advances by a fixed step while `pos_adv` is high. While the external configuration loader reports busy, every read returns the status byte.

Register map: 0x00 status (bit 0 busy, bit 1 data valid, other bits 0), 0x01 command, 0x02 life counter, 0x03/0x04 singleturn low/high byte, 0x05 multiturn, 0x06 interpolator, 0x08..0x0F eight read/write scratch registers. The status, life and snapshot registers are read-only, and unmapped addresses read as 0x00.

Top module: `mpx_bus_slave`

## Requirements
- R1: After reset the output enable is low, the next write is taken as an address, the status byte reads 0x00 and the life counter reads 0x00.
- R2: The first write strobe of a transaction only loads the register pointer; no register content changes.
- R3: The second write strobe stores the bus byte into the addressed scratch register (0x08..0x0F).
- R4: A read strobe after an address write drives the addressed register onto `data_out` and ends the transaction, so the next write is again an address. Unmapped addresses read 0x00.
- R5: While `cfg_busy` is high, every read returns the status byte (bit 0 = busy, bit 1 = valid), whatever address is set.
- R6: Writing 0x00 to the command register (0x01) requests a snapshot; writing any other value to it has no effect.
- R7: A falling edge on `snap_req_n` requests a snapshot, whether or not the block is selected.
- R8: The life counter (0x02) advances by one on each accepted request and wraps from 0xFF to 0x00.
- R9: The valid flag clears in the clock after a request is detected and sets two clocks after that. At that point 0x06 holds position bits 7:0, 0x03/0x04 hold bits 15:8 and 23:16, and 0x05 holds bits 31:24.
- R10: A strobe that rises while the other strobe is low, or after both were low together, is ignored, and the output enable stays low during the overlap.
- R11: Strobes have no effect unless `bus_sel_n` is low when they rise.
- R12: `data_oe` is high only while `bus_sel_n` and `rd_stb_n` are low and `wr_stb_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low chip select |
| rd_stb_n | input | 1 | Active-low read strobe |
| wr_stb_n | input | 1 | Active-low write strobe |
| snap_req_n | input | 1 | Active-low snapshot request pin |
| data_in | input | 8 | Bus byte from the host |
| data_out | output | 8 | Byte driven to the host |
| data_oe | output | 1 | Output enable for the data pads |
| cfg_busy | input | 1 | Configuration loader busy |
| pos_adv | input | 1 | Advance the model position source by one step |

## Verification
On every cycle, the assertions check the timing of the valid flag around a request, the one-step advance and the hold of the life counter, the read-only effect of an address write on the scratch registers, the phase tracker holding still while the block is deselected, and that a non-sample command write does not count. Only the bench scenarios show the end-to-end bus behaviour: the address-then-data order over all scratch registers, the busy override, the snapshot byte layout against an arithmetically tracked position, the life counter wrapping after a long run of requests, and the rejection of overlapping or deselected strobes.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  localparam logic [7:0] ADDR_STATUS = 8'h00;
  localparam logic [7:0] ADDR_CMD    = 8'h01;
  localparam logic [7:0] ADDR_LIFE   = 8'h02;
  localparam logic [7:0] ADDR_ST_LO  = 8'h03;
  localparam logic [7:0] ADDR_ST_HI  = 8'h04;
  localparam logic [7:0] ADDR_MT     = 8'h05;
  localparam logic [7:0] ADDR_IP     = 8'h06;
  localparam logic [7:0] CFG_BASE    = 8'h08;
  localparam logic [7:0] CMD_SAMPLE  = 8'h00;

  localparam int POS_W = 32;

  typedef struct packed {
    logic [7:0]  mt;
    logic [15:0] st;
    logic [7:0]  ip;
  } pos_t;

  function automatic logic [7:0] status_byte(input logic busy, input logic valid);
    return {6'b0, valid, busy};
  endfunction

  function automatic logic [7:0] life_next(input logic [7:0] cur);
    return cur + 8'd1;
  endfunction

  function automatic logic [POS_W-1:0] pos_next(input logic [POS_W-1:0] cur,
                                                input logic [POS_W-1:0] step);
    return cur + step;
  endfunction

endpackage

// File: rtl/mpb_sync.sv
module mpb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= INIT;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= INIT;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= INIT;
    else        q_prev <= q;
  end

endmodule

// File: rtl/mpb_posctr.sv
module mpb_posctr
  import mpb_pkg::*;
#(
  parameter logic [POS_W-1:0] STEP = 32'h0001_0307
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output pos_t pos
);

  logic [POS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= pos_next(cnt_q, STEP);
  end

  assign pos = pos_t'(cnt_q);

endmodule

// File: rtl/mpb_snap.sv
module mpb_snap
  import mpb_pkg::*;
#(
  parameter int LIFE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  pos_t              pos,
  output pos_t              snap,
  output logic              valid,
  output logic [LIFE_W-1:0] life
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      valid <= 1'b0;
      snap  <= '0;
      life  <= '0;
    end else begin
      stg_q <= {stg_q[0], req};
      if (req)           valid <= 1'b0;
      else if (stg_q[1]) valid <= 1'b1;
      if (stg_q[1])      snap  <= pos;
      if (req)           life  <= LIFE_W'(life_next(8'(life)));
    end
  end

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !valid);

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req, 2) && !$past(req) && !req) |=> valid);

  p_life_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (life == LIFE_W'($past(life) + 1'b1)));

  p_life_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(life));

endmodule

// File: rtl/mpb_regfile.sv
module mpb_regfile
  import mpb_pkg::*;
#(
  parameter int CFG_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  input  logic [7:0]            status,
  input  logic [7:0]            life,
  input  pos_t                  snap,
  output logic [7:0]            rdata,
  output logic [CFG_REGS*8-1:0] cfg_flat
);

  localparam int CFG_IW = $clog2(CFG_REGS);

  logic [7:0] cfg_r [CFG_REGS];
  logic       cfg_hit;

  assign cfg_hit = (addr[7:CFG_IW] == CFG_BASE[7:CFG_IW]);

  for (genvar i = 0; i < CFG_REGS; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_r[i] <= '0;
      else if (we && cfg_hit && (addr[CFG_IW-1:0] == CFG_IW'(i)))
        cfg_r[i] <= wdata;
    end
    assign cfg_flat[i*8 +: 8] = cfg_r[i];
  end

  always_comb begin
    rdata = 8'h00;
    if (cfg_hit) begin
      rdata = cfg_r[addr[CFG_IW-1:0]];
    end else begin
      case (addr)
        ADDR_STATUS: rdata = status;
        ADDR_LIFE:   rdata = life;
        ADDR_ST_LO:  rdata = snap.st[7:0];
        ADDR_ST_HI:  rdata = snap.st[15:8];
        ADDR_MT:     rdata = snap.mt;
        ADDR_IP:     rdata = snap.ip;
        default:     rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/mpx_bus_slave.sv
module mpx_bus_slave
  import mpb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_REGS = 8,
  parameter logic [POS_W-1:0] POS_STEP = 32'h0001_0307
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel_n,
  input  logic       rd_stb_n,
  input  logic       wr_stb_n,
  input  logic       snap_req_n,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  input  logic       cfg_busy,
  input  logic       pos_adv
);

  localparam int CTL_W = 4;

  logic [CTL_W-1:0] ctl_q, ctl_p;
  logic [7:0]       din_q, din_p;
  logic             cs_q, rd_q, rd_p, wr_q, wr_p, snp_q, snp_p;

  mpb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT('1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_sel_n, rd_stb_n, wr_stb_n, snap_req_n}),
    .q(ctl_q), .q_prev(ctl_p)
  );

  mpb_sync #(.W(8), .STAGES(SYNC_STAGES), .INIT('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(data_in), .q(din_q), .q_prev(din_p)
  );

  assign cs_q  = ctl_q[3];
  assign rd_q  = ctl_q[2];
  assign rd_p  = ctl_p[2];
  assign wr_q  = ctl_q[1];
  assign wr_p  = ctl_p[1];
  assign snp_q = ctl_q[0];
  assign snp_p = ctl_p[0];

  // overlap tracker: set when both strobes low, cleared once both are high
  logic ill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ill_q <= 1'b0;
    else if (!rd_q && !wr_q) ill_q <= 1'b1;
    else if (rd_q && wr_q)   ill_q <= 1'b0;
  end

  logic rd_evt, wr_evt;
  assign rd_evt = rd_q && !rd_p && wr_q && !cs_q && !ill_q;
  assign wr_evt = wr_q && !wr_p && rd_q && !cs_q && !ill_q;

  logic       expect_addr;
  logic [7:0] addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_addr <= 1'b1;
      addr_q      <= '0;
    end else if (wr_evt) begin
      if (expect_addr) addr_q <= din_q;
      expect_addr <= !expect_addr;
    end else if (rd_evt) begin
      expect_addr <= 1'b1;
    end
  end

  logic reg_we, cmd_req, pin_req, req;
  assign reg_we  = wr_evt && !expect_addr;
  assign cmd_req = reg_we && (addr_q == ADDR_CMD) && (din_q == CMD_SAMPLE);
  assign pin_req = snp_p && !snp_q;
  assign req     = cmd_req || pin_req;

  pos_t       pos, snap;
  logic       valid;
  logic [7:0] life;

  mpb_posctr #(.STEP(POS_STEP)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(pos_adv), .pos(pos)
  );

  mpb_snap #(.LIFE_W(8)) u_snap (
    .clk(clk), .rst_n(rst_n), .req(req), .pos(pos),
    .snap(snap), .valid(valid), .life(life)
  );

  logic [7:0]            status, rdata;
  logic [CFG_REGS*8-1:0] cfg_flat;
  assign status = status_byte(cfg_busy, valid);

  mpb_regfile #(.CFG_REGS(CFG_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(addr_q), .wdata(din_q),
    .status(status), .life(life), .snap(snap),
    .rdata(rdata), .cfg_flat(cfg_flat)
  );

  assign data_out = cfg_busy ? status : rdata;
  assign data_oe  = !bus_sel_n && !rd_stb_n && wr_stb_n;

  p_addr_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && expect_addr) |=> $stable(cfg_flat));

  p_desel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> $stable(expect_addr));

  p_overlap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ($stable(expect_addr) && $stable(addr_q) && $stable(cfg_flat)));

  p_cmd_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && addr_q == ADDR_CMD && din_q != CMD_SAMPLE && !pin_req) |=> $stable(life));

endmodule

// File: tb/mpx_bus_slave_test.sv
`timescale 1ns/1ps
module mpx_bus_slave_test;

  localparam logic [31:0] STEP = 32'h0001_0307;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel_n = 1'b1, rd_stb_n = 1'b1, wr_stb_n = 1'b1, snap_req_n = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe;
  logic       cfg_busy = 1'b0, pos_adv = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] pos_exp = '0;
  logic [7:0]  life_exp = '0;
  logic [7:0]  cfg_exp [8];

  always #2 clk = ~clk;

  mpx_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .rd_stb_n(rd_stb_n),
    .wr_stb_n(wr_stb_n), .snap_req_n(snap_req_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .cfg_busy(cfg_busy), .pos_adv(pos_adv)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] b);
    @(negedge clk); data_in = b; bus_sel_n = 1'b0;
    idle(1); wr_stb_n = 1'b0;
    idle(5); wr_stb_n = 1'b1;
    idle(5); bus_sel_n = 1'b1;
    idle(2);
  endtask

  task automatic bus_read(output logic [7:0] b, output logic oe);
    @(negedge clk); bus_sel_n = 1'b0;
    idle(1); rd_stb_n = 1'b0;
    idle(6); b = data_out; oe = data_oe;
    rd_stb_n = 1'b1;
    idle(5); bus_sel_n = 1'b1;
    idle(2);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus_write(a); bus_write(d);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] b);
    logic oe;
    bus_write(a); bus_read(b, oe);
    chk(oe == 1'b1, "R12 oe during read", oe, 1);
  endtask

  task automatic pulse_latch();
    @(negedge clk); snap_req_n = 1'b0;
    idle(4); snap_req_n = 1'b1;
    idle(8);
    life_exp = life_exp + 8'd1;
  endtask

  task automatic move_pos(input int n);
    @(negedge clk); pos_adv = 1'b1;
    idle(n); pos_adv = 1'b0;
    pos_exp = pos_exp + STEP * 32'(n);
  endtask

  task automatic check_snap(input string rq);
    logic [7:0] v;
    rd_reg(8'h06, v); chk(v == pos_exp[7:0],   rq, v, pos_exp[7:0]);
    rd_reg(8'h03, v); chk(v == pos_exp[15:8],  rq, v, pos_exp[15:8]);
    rd_reg(8'h04, v); chk(v == pos_exp[23:16], rq, v, pos_exp[23:16]);
    rd_reg(8'h05, v); chk(v == pos_exp[31:24], rq, v, pos_exp[31:24]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       oe;

    idle(5); rst_n = 1'b1; idle(3);

    // R1 reset state
    chk(data_oe == 1'b0, "R1 oe after reset", data_oe, 0);
    rd_reg(8'h00, v); chk(v == 8'h00, "R1 status after reset", v, 0);
    rd_reg(8'h02, v); chk(v == 8'h00, "R1 life after reset", v, 0);

    // R3 / R4 scratch sweep
    for (int i = 0; i < 8; i++) begin
      cfg_exp[i] = 8'(i * 37 + 5);
      wr_reg(8'(8 + i), cfg_exp[i]);
    end
    for (int i = 0; i < 8; i++) begin
      rd_reg(8'(8 + i), v);
      chk(v == cfg_exp[i], "R3 scratch readback", v, cfg_exp[i]);
    end
    rd_reg(8'h20, v); chk(v == 8'h00, "R4 unmapped reads zero", v, 0);

    // R2 address-only write leaves registers untouched
    bus_write(8'h0A);
    bus_read(v, oe); chk(v == cfg_exp[2], "R2 address write stores nothing", v, cfg_exp[2]);

    // R4 after a read the next write is an address
    wr_reg(8'h08, 8'hC3); cfg_exp[0] = 8'hC3;
    rd_reg(8'h08, v); chk(v == 8'hC3, "R4 phase restarts after read", v, 8'hC3);
    rd_reg(8'h0A, v); chk(v == cfg_exp[2], "R4 neighbour untouched", v, cfg_exp[2]);

    // R5 busy override
    bus_write(8'h08);
    cfg_busy = 1'b1;
    bus_read(v, oe); chk(v == 8'h01, "R5 busy returns status", v, 8'h01);
    cfg_busy = 1'b0;
    bus_read(v, oe); chk(v == cfg_exp[0], "R5 override released", v, cfg_exp[0]);

    // R6 command request
    move_pos(123);
    wr_reg(8'h01, 8'h00); life_exp = life_exp + 8'd1;
    idle(4);
    rd_reg(8'h02, v); chk(v == life_exp, "R6 command bumps life", v, life_exp);
    rd_reg(8'h00, v); chk(v == 8'h02, "R9 valid after command", v, 8'h02);
    check_snap("R9 snapshot after command");
    wr_reg(8'h01, 8'h5A);
    rd_reg(8'h02, v); chk(v == life_exp, "R6 other command ignored", v, life_exp);

    // R7 latch pin request
    move_pos(77);
    pulse_latch();
    rd_reg(8'h02, v); chk(v == life_exp, "R7 latch bumps life", v, life_exp);
    check_snap("R7 snapshot after latch");

    // R9 valid flag timing seen on the bus during an open read of status
    bus_write(8'h00);
    @(negedge clk); bus_sel_n = 1'b0;
    idle(1); rd_stb_n = 1'b0;
    idle(6); chk(data_out[1] == 1'b1, "R9 valid before request", data_out[1], 1);
    snap_req_n = 1'b0;
    idle(2); chk(data_out[1] == 1'b1, "R9 valid two clocks after pin", data_out[1], 1);
    idle(1); chk(data_out[1] == 1'b0, "R9 valid cleared", data_out[1], 0);
    snap_req_n = 1'b1;
    idle(1); chk(data_out[1] == 1'b0, "R9 valid still clear", data_out[1], 0);
    idle(1); chk(data_out[1] == 1'b1, "R9 valid set again", data_out[1], 1);
    rd_stb_n = 1'b1; idle(5); bus_sel_n = 1'b1; idle(4);
    life_exp = life_exp + 8'd1;
    check_snap("R9 snapshot unchanged position");

    // R8 life counter wrap
    for (int k = 0; k < 252; k++) pulse_latch();
    rd_reg(8'h02, v); chk(v == 8'hFF, "R8 life reaches 0xFF", v, 8'hFF);
    pulse_latch(); pulse_latch();
    rd_reg(8'h02, v); chk(v == 8'h01 && v == life_exp, "R8 life wraps", v, life_exp);

    // R10 overlapping strobes
    bus_write(8'h0B);
    @(negedge clk); bus_sel_n = 1'b0; data_in = 8'hEE;
    idle(1); wr_stb_n = 1'b0;
    idle(1); rd_stb_n = 1'b0;
    idle(3); chk(data_oe == 1'b0, "R10 oe low in overlap", data_oe, 0);
    wr_stb_n = 1'b1; idle(5);
    rd_stb_n = 1'b1; idle(5);
    bus_sel_n = 1'b1; idle(2);
    bus_write(8'h3C);
    rd_reg(8'h0B, v); chk(v == 8'h3C, "R10 overlap ignored", v, 8'h3C);

    // R11 deselected strobes
    @(negedge clk); data_in = 8'h08; wr_stb_n = 1'b0;
    idle(5); wr_stb_n = 1'b1; idle(5);
    rd_stb_n = 1'b0; idle(3);
    chk(data_oe == 1'b0, "R11 oe low without select", data_oe, 0);
    rd_stb_n = 1'b1; idle(5);
    wr_reg(8'h0C, 8'h99);
    rd_reg(8'h0C, v); chk(v == 8'h99, "R11 deselected write ignored", v, 8'h99);

    // R12 enable needs read strobe with write strobe high
    @(negedge clk); bus_sel_n = 1'b0; wr_stb_n = 1'b0;
    idle(2); chk(data_oe == 1'b0, "R12 oe low on write", data_oe, 0);
    wr_stb_n = 1'b1; idle(1); rd_stb_n = 1'b0;
    idle(1); chk(data_oe == 1'b1, "R12 oe high on read", data_oe, 1);
    rd_stb_n = 1'b1; idle(5); bus_sel_n = 1'b1; idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule